// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Clock Divider

This block divides a fast input clock, which stands in for the oscillator feedback of a frequency synthesizer, by a programmable total ratio N = P·NP + A. The ratio is not produced by one long programmable counter. A small prescaler counter runs at the input rate and divides by either P or P+1. A swallow counter, preset to A, holds the prescaler in its P+1 modulus. A main counter, preset to NP, counts prescaler periods until the division cycle ends.

Every prescaler period is one tick. Both counters step down on each tick. The swallow counter stops when it reaches zero, and the mode-control output then drops so that the prescaler divides by P for the rest of the cycle. When the main counter runs out, the block emits one pulse at the reference rate for the phase comparator and reloads both presets from its inputs. The modulus P and the preset widths are parameters. A build option chooses whether the output pulse comes straight from the counter state or is delayed by one flop.

Top module: `swallow_divider`

## Requirements
- R1: For any legal setting, the distance between consecutive output pulses is exactly P·NP + A input clocks. The default P is 64, NP is 11 bits wide and A is 7 bits wide.
- R2: Within each division cycle, mode control is high for the first A prescaler periods, which is (P+1)·A input clocks. It is low for the remaining (NP−A)·P clocks and does not rise again until the next cycle starts.
- R3: With A = 0, mode control stays low for the whole cycle and the ratio is P·NP.
- R4: The NP and A inputs are sampled only at the edge that starts a cycle. A change applied partway through a cycle leaves that cycle's length unchanged and takes effect from the next cycle.
- R5: The output pulse is high for exactly one input clock, and there is exactly one pulse per division cycle.
- R6: While reset is asserted, the pulse and mode control are both low. The first cycle starts on the first clock edge after reset is released. In the unregistered build, the first pulse is high during the N-th clock after that release.
- R7: The tightest legal setting, NP = A + 1, works: mode control stays high through all but the last prescaler period, and it is low on the clock that ends the cycle. Every captured setting must satisfy NP > A.
- R8: With the registered-pulse option, the pulse appears one clock later than in the unregistered build, so the first pulse is high in clock N+1 after reset. The spacing between pulses and the mode-control timing are the same as in the unregistered build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| np_set | input | NP_W (11) | Main-counter preset NP, sampled at cycle start |
| a_set | input | A_W (7) | Swallow-counter preset A, sampled at cycle start |
| mode_hi | output | 1 | Prescaler modulus select: high selects P+1, low selects P |
| ref_pulse | output | 1 | One-clock pulse, one per division cycle |

## Verification
The bench builds two copies of the block side by side.

The first uses the defaults (P = 64, 11-bit NP, 7-bit A, unregistered pulse). It runs realistic ratios up to about 8300, including A at its 7-bit maximum and the NP = A + 1 edge.

The second uses P = 4 with 5-bit NP, 3-bit A and the registered-pulse option. Its short cycles of a few dozen clocks make the one-clock shift of the registered variant and the small-modulus corner cases cheap to observe.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

   // Modulus select passed from the swallow counter to the prescaler.
   typedef enum logic {
      MOD_P  = 1'b0,
      MOD_P1 = 1'b1
   } modsel_e;

endpackage

// File: rtl/swallow_prescaler.sv
// Dual-modulus prescaler modelled as a digital counter on the fast clock.
module swallow_prescaler
   import swallow_pkg::*;
#(
   parameter int P_MOD = 64
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    active,
   input  modsel_e msel,
   output logic    tick
);

   localparam int PW = $clog2(P_MOD + 1);
   localparam logic [PW-1:0] TOP_HI = PW'(P_MOD);
   localparam logic [PW-1:0] TOP_LO = PW'(P_MOD - 1);

   logic [PW-1:0] pcnt;
   logic [PW-1:0] term;

   assign term = (msel == MOD_P1) ? TOP_HI : TOP_LO;
   assign tick = active && (pcnt == term);

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt <= '0;
      end else if (!active || tick) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + PW'(1);
      end
   end

   AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
      pcnt <= TOP_HI); // R1

endmodule

// File: rtl/swallow_acount.sv
// Swallow counter: holds the prescaler in P+1 until it has counted A ticks.
module swallow_acount
   import swallow_pkg::*;
#(
   parameter int A_W = 7
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           tick,
   input  logic [A_W-1:0] a_in,
   output modsel_e        msel
);

   logic [A_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= a_in;
      end else if (tick && (cnt != '0)) begin
         cnt <= cnt - A_W'(1);
      end
   end

   assign msel = (cnt != '0) ? MOD_P1 : MOD_P;

   AST_SWALLOW_PARKED: assert property (@(posedge clk) disable iff (rst)
      ((cnt == '0) && !load) |=> (cnt == '0)); // R2

endmodule

// File: rtl/swallow_main.sv
// Main counter: counts prescaler periods and marks the end of a division cycle.
module swallow_main #(
   parameter int NP_W = 11,
   parameter int A_W  = 7
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [NP_W-1:0] np_in,
   input  logic [A_W-1:0]  a_in,
   output logic            active,
   output logic            load,
   output logic            last
);

   logic [NP_W-1:0] cnt;

   assign active = (cnt != '0);
   assign last   = tick && (cnt == NP_W'(1));
   assign load   = !active || last;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= np_in;
      end else if (tick) begin
         cnt <= cnt - NP_W'(1);
      end
   end

   AST_NP_ABOVE_A: assert property (@(posedge clk) disable iff (rst)
      load |-> (np_in > NP_W'(a_in))); // R7

endmodule

// File: rtl/swallow_divider.sv
// Pulse-swallow programmable divider: ratio P*NP + A.
module swallow_divider
   import swallow_pkg::*;
#(
   parameter int P_MOD     = 64,
   parameter int NP_W      = 11,
   parameter int A_W       = 7,
   parameter bit PULSE_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NP_W-1:0] np_set,
   input  logic [A_W-1:0]  a_set,
   output logic            mode_hi,
   output logic            ref_pulse
);

   // Elaboration-time parameter checks.
   if (P_MOD < 2) begin : g_bad_pmod
      $error("swallow_divider: P_MOD must be at least 2");
   end
   if (NP_W < 2) begin : g_bad_npw
      $error("swallow_divider: NP_W must be at least 2");
   end
   if ((A_W < 1) || (A_W > NP_W)) begin : g_bad_aw
      $error("swallow_divider: A_W must lie in 1..NP_W");
   end

   logic    tick;
   logic    active;
   logic    load;
   logic    last;
   modsel_e msel;

   swallow_prescaler #(.P_MOD(P_MOD)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .active (active),
      .msel   (msel),
      .tick   (tick)
   );

   swallow_acount #(.A_W(A_W)) u_swal (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .tick (tick),
      .a_in (a_set),
      .msel (msel)
   );

   swallow_main #(.NP_W(NP_W), .A_W(A_W)) u_main (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .np_in  (np_set),
      .a_in   (a_set),
      .active (active),
      .load   (load),
      .last   (last)
   );

   assign mode_hi = (msel == MOD_P1);

   if (PULSE_REG) begin : g_pulse_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            pulse_q <= 1'b0;
         end else begin
            pulse_q <= last;
         end
      end
      assign ref_pulse = pulse_q;
   end else begin : g_pulse_comb
      assign ref_pulse = last;
   end

   AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
      ref_pulse |=> !ref_pulse); // R5

   AST_MODE_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!tick && !load) |=> (mode_hi == $past(mode_hi))); // R2

   AST_MODE_LOW_AT_END: assert property (@(posedge clk) disable iff (rst)
      last |-> !mode_hi); // R7

   AST_MODE_NO_REARM: assert property (@(posedge clk) disable iff (rst)
      (!mode_hi && !load) |=> !mode_hi); // R3

endmodule

// File: tb/swallow_divider_tb_top.sv
`timescale 1ns/1ps
module swallow_divider_tb_top;

   localparam int PB = 64;
   localparam int PS = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [10:0] np_b = 11'd20;
   logic [6:0]  a_b  = 7'd5;
   logic [4:0]  np_s = 5'd3;
   logic [2:0]  a_s  = 3'd2;
   logic        mode_b, pulse_b, mode_s, pulse_s;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   swallow_divider dut_i (
      .clk(clk), .rst(rst), .np_set(np_b), .a_set(a_b),
      .mode_hi(mode_b), .ref_pulse(pulse_b));

   swallow_divider #(.P_MOD(PS), .NP_W(5), .A_W(3), .PULSE_REG(1'b1)) dut_small_i (
      .clk(clk), .rst(rst), .np_set(np_s), .a_set(a_s),
      .mode_hi(mode_s), .ref_pulse(pulse_s));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic pulse_of(input bit sel);
      return sel ? pulse_s : pulse_b;
   endfunction

   function automatic logic mode_of(input bit sel);
      return sel ? mode_s : mode_b;
   endfunction

   task automatic wait_pulse(input bit sel);
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!pulse_of(sel) && guard < 200000);
   endtask

   // Count clocks from the first pulse after the call to the one after it.
   task automatic measure(input bit sel, output int len, output int hi);
      wait_pulse(sel);
      @(negedge clk);
      chk(pulse_of(sel) == 1'b0, "R5 pulse width", int'(pulse_of(sel)), 0);
      len = 1;
      hi  = int'(mode_of(sel));
      while (!pulse_of(sel) && len < 200000) begin
         @(negedge clk);
         len++;
         hi += int'(mode_of(sel));
      end
   endtask

   task automatic first_pulse(input bit sel, input int exp, input string req);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!pulse_of(sel) && n < 200000);
      chk(n == exp, req, n, exp);
   endtask

   task automatic t_reset;
      repeat (4) @(negedge clk);
      chk(pulse_b == 1'b0, "R6 pulse in reset", int'(pulse_b), 0);
      chk(mode_b  == 1'b0, "R6 mode in reset",  int'(mode_b), 0);
      chk(pulse_s == 1'b0 && mode_s == 1'b0, "R6 small outputs in reset",
          int'({pulse_s, mode_s}), 0);
      rst = 1'b0;
      fork
         first_pulse(1'b0, PB * 20 + 5, "R6 first pulse");
         first_pulse(1'b1, PS * 3 + 2 + 1, "R8 first pulse registered");
      join
   endtask

   task automatic t_ratio_big(input int np, input int a, input string req);
      int len, hi;
      @(negedge clk);
      np_b = 11'(np);
      a_b  = 7'(a);
      measure(1'b0, len, hi);
      chk(len == PB * np + a, {req, " R1 ratio"}, len, PB * np + a);
      chk(hi == (PB + 1) * a, {req, " R2 mode-high clocks"}, hi, (PB + 1) * a);
   endtask

   task automatic t_ratio_small(input int np, input int a, input string req);
      int len, hi;
      @(negedge clk);
      np_s = 5'(np);
      a_s  = 3'(a);
      measure(1'b1, len, hi);
      chk(len == PS * np + a, {req, " R8 ratio registered"}, len, PS * np + a);
      chk(hi == (PS + 1) * a, {req, " R8 mode-high clocks"}, hi, (PS + 1) * a);
   endtask

   task automatic t_midchange;
      int len;
      @(negedge clk);
      np_b = 11'd30;
      a_b  = 7'd10;
      wait_pulse(1'b0);
      len = 0;
      do begin
         @(negedge clk);
         len++;
         if (len == 200) begin
            np_b = 11'd50;
            a_b  = 7'd3;
         end
      end while (!pulse_b && len < 200000);
      chk(len == PB * 30 + 10, "R4 cycle keeps old preset", len, PB * 30 + 10);
      len = 0;
      do begin
         @(negedge clk);
         len++;
      end while (!pulse_b && len < 200000);
      chk(len == PB * 50 + 3, "R4 next cycle uses new preset", len, PB * 50 + 3);
   endtask

   initial begin
      t_reset();
      t_ratio_big(20, 5, "R1 base");
      t_ratio_big(37, 0, "R3 A=0");
      t_ratio_big(16, 15, "R7 NP=A+1");
      t_ratio_big(128, 127, "R1 A max");
      t_ratio_big(100, 63, "R2 mid");
      t_midchange();
      t_ratio_small(3, 2, "small");
      t_ratio_small(5, 0, "R3 small A=0");
      t_ratio_small(7, 6, "R7 small NP=A+1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule